// File: doc/BRIEF.md
# Chained Control Register Node

This block is one stop on a ring of control-register peripherals. A bus master drives a 10-bit register address and separate read and write strobes to every node. Data travels node to node on a 32-bit chain. Each node accepts the chain word from the node before it and hands a word on to the node after it. When the address falls outside this node's window, the word goes through untouched. When a read falls inside the window, the node puts the selected register in place of the upstream word. During a write, the upstream chain word is the write data.

The node holds `NUM_REGS` 32-bit registers starting at `BASE_ADDR`. A parameter chooses how the acknowledge leaves the node. In one option it is ORed straight onto the upstream acknowledge. In the other, both the acknowledge and the data word are captured in flops and sent on one cycle later. The node also passes the read and write strobes on to downstream logic, and it blocks them whenever the access belongs to its own window.

Top module: `chain_reg_node`

## Requirements
- R1: An address hits the node when `BASE_ADDR <= req_addr < BASE_ADDR + NUM_REGS`. The register index is `req_addr - BASE_ADDR`. Addresses one below the window and one past it are misses.
- R2: A cycle with `req_wr`=1, `req_rd`=0 and an address hit loads `chain_din` into the indexed register at that clock edge.
- R3: A write to an address outside the window changes none of the local registers.
- R4: When there is no read hit, `chain_dout` equals `chain_din`. In OR mode this holds in the same cycle.
- R5: A read hit (`req_rd`=1, `req_wr`=0) puts the indexed register's value on `chain_dout` in place of `chain_din`.
- R6: The local acknowledge goes high in the cycle after a legal request that hits. It stays high for as long as that request is held, and it is low in the cycle after the request drops.
- R7: OR mode (`ACK_CHAINED`=0): `chain_ack_out` is the local acknowledge ORed combinationally with `chain_ack_in`.
- R8: Chained mode (`ACK_CHAINED`=1): `chain_ack_out` and `chain_dout` are registered. After an edge they show the acknowledge (local OR upstream) and the data word that were formed from the inputs present at that edge.
- R9: `fwd_rd` and `fwd_wr` follow `req_rd` and `req_wr` for misses, and both are 0 for hits.
- R10: A cycle with `req_rd` and `req_wr` both high is illegal. It writes no register, gives no acknowledge, and `chain_dout` carries `chain_din`.
- R11: A synchronous active-high reset clears every register to zero and drives the acknowledge output low. In chained mode it also clears the registered data word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| req_addr | input | 10 | Register address from the master |
| req_rd | input | 1 | Read strobe |
| req_wr | input | 1 | Write strobe |
| chain_din | input | 32 | Chain word from the previous node (write data during writes) |
| chain_ack_in | input | 1 | Acknowledge from the previous node |
| chain_dout | output | 32 | Chain word to the next node |
| chain_ack_out | output | 1 | Acknowledge to the next node or to the master |
| fwd_rd | output | 1 | Read strobe passed downstream, blocked on a hit |
| fwd_wr | output | 1 | Write strobe passed downstream, blocked on a hit |

## Verification
The bench probes the addresses just below and just past the window. A decoder with an off-by-one error would then capture a write meant for another node, or would replace the chain word on a miss. It holds a read for several cycles and then drops it, which exposes an acknowledge that pulses only once or lingers after the request ends. It drives read and write together on a hit, so a node that treats that cycle as a write would corrupt a register. Both acknowledge options run on the same stimulus. A chained node that forgets to delay its data word, or an OR node that drops the upstream acknowledge, therefore shows up as a mismatch.

// File: rtl/chain_reg_pkg.sv
package chain_reg_pkg;

    localparam int ADDR_W = 10;
    localparam int DATA_W = 32;

    typedef logic [ADDR_W-1:0] addr_t;
    typedef logic [DATA_W-1:0] data_t;

    typedef struct packed {
        addr_t addr;
        logic  rd;
        logic  wr;
    } bus_req_t;

    typedef enum logic [1:0] {
        OP_IDLE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_BAD   = 2'b11
    } op_e;

    function automatic op_e classify(input logic rd, input logic wr);
        case ({rd, wr})
            2'b10:   return OP_READ;
            2'b01:   return OP_WRITE;
            2'b11:   return OP_BAD;
            default: return OP_IDLE;
        endcase
    endfunction

    function automatic logic in_window(input addr_t a, input addr_t base, input int n);
        return (int'(a) >= int'(base)) && (int'(a) < int'(base) + n);
    endfunction

endpackage

// File: rtl/chain_reg_decode.sv
module chain_reg_decode
    import chain_reg_pkg::*;
#(
    parameter chain_reg_pkg::addr_t BASE_ADDR = 10'h1A0,
    parameter int NUM_REGS = 4,
    parameter int IDX_W    = 2
) (
    input  bus_req_t         req,
    output logic             hit,
    output logic [IDX_W-1:0] idx,
    output logic             rd_sel,
    output logic             wr_sel,
    output logic             ack_next,
    output logic             fwd_rd,
    output logic             fwd_wr
);
    op_e op;

    always_comb begin
        op       = classify(req.rd, req.wr);
        hit      = in_window(req.addr, BASE_ADDR, NUM_REGS);
        idx      = IDX_W'(req.addr - BASE_ADDR);
        rd_sel   = hit && (op == OP_READ);
        wr_sel   = hit && (op == OP_WRITE);
        ack_next = rd_sel || wr_sel;
        fwd_rd   = req.rd && !hit;
        fwd_wr   = req.wr && !hit;
    end

endmodule

// File: rtl/chain_reg_bank.sv
module chain_reg_bank
    import chain_reg_pkg::*;
#(
    parameter int NUM_REGS = 4,
    parameter int IDX_W    = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             wr_sel,
    input  logic [IDX_W-1:0] idx,
    input  data_t            wdata,
    output data_t            rd_data
);
    data_t [NUM_REGS-1:0] regs_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            regs_q <= '0;
        end else begin
            for (int i = 0; i < NUM_REGS; i++) begin
                if (wr_sel && (int'(idx) == i)) regs_q[i] <= wdata;
            end
        end
    end

    always_comb begin
        rd_data = (int'(idx) < NUM_REGS) ? regs_q[idx] : '0;
    end

    AST_WRITE_LANDS: assert property (@(posedge clk) disable iff (rst)
        wr_sel |=> regs_q[$past(idx)] == $past(wdata)); // R2

    AST_IDLE_HOLDS: assert property (@(posedge clk) disable iff (rst)
        !wr_sel |=> $stable(regs_q)); // R3

endmodule

// File: rtl/chain_reg_link.sv
module chain_reg_link
    import chain_reg_pkg::*;
#(
    parameter bit ACK_CHAINED = 1'b0
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  rd_sel,
    input  data_t rd_data,
    input  data_t chain_din,
    input  logic  ack_next,
    input  logic  chain_ack_in,
    output logic  loc_ack,
    output data_t chain_dout,
    output logic  chain_ack_out
);
    data_t word_sel;
    logic  loc_ack_q;

    always_comb word_sel = rd_sel ? rd_data : chain_din;

    always_ff @(posedge clk) begin
        if (rst) loc_ack_q <= 1'b0;
        else     loc_ack_q <= ack_next;
    end

    assign loc_ack = loc_ack_q;

    generate
        if (ACK_CHAINED) begin : g_chained
            data_t dout_q;
            logic  ack_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    dout_q <= '0;
                    ack_q  <= 1'b0;
                end else begin
                    dout_q <= word_sel;
                    ack_q  <= ack_next || chain_ack_in;
                end
            end
            assign chain_dout    = dout_q;
            assign chain_ack_out = ack_q;

            AST_CHAIN_ACK_LAG: assert property (@(posedge clk) disable iff (rst)
                chain_ack_in |=> chain_ack_out); // R8
        end else begin : g_ored
            assign chain_dout    = word_sel;
            assign chain_ack_out = loc_ack_q || chain_ack_in;

            AST_OR_UPSTREAM: assert property (@(posedge clk) disable iff (rst)
                chain_ack_in |-> chain_ack_out); // R7
        end
    endgenerate

endmodule

// File: rtl/chain_reg_node.sv
module chain_reg_node
    import chain_reg_pkg::*;
#(
    parameter chain_reg_pkg::addr_t BASE_ADDR = 10'h1A0,
    parameter int NUM_REGS    = 4,
    parameter bit ACK_CHAINED = 1'b0
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [9:0]  req_addr,
    input  logic        req_rd,
    input  logic        req_wr,
    input  logic [31:0] chain_din,
    input  logic        chain_ack_in,
    output logic [31:0] chain_dout,
    output logic        chain_ack_out,
    output logic        fwd_rd,
    output logic        fwd_wr
);
    localparam int IDX_W = (NUM_REGS > 1) ? $clog2(NUM_REGS) : 1;

    bus_req_t         req;
    logic             hit, rd_sel, wr_sel, ack_next, loc_ack;
    logic [IDX_W-1:0] idx;
    data_t            rd_data;

    assign req = '{addr: req_addr, rd: req_rd, wr: req_wr};

    chain_reg_decode #(.BASE_ADDR(BASE_ADDR), .NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_dec (
        .req(req), .hit(hit), .idx(idx), .rd_sel(rd_sel), .wr_sel(wr_sel),
        .ack_next(ack_next), .fwd_rd(fwd_rd), .fwd_wr(fwd_wr)
    );

    chain_reg_bank #(.NUM_REGS(NUM_REGS), .IDX_W(IDX_W)) u_bank (
        .clk(clk), .rst(rst), .wr_sel(wr_sel), .idx(idx),
        .wdata(chain_din), .rd_data(rd_data)
    );

    chain_reg_link #(.ACK_CHAINED(ACK_CHAINED)) u_link (
        .clk(clk), .rst(rst), .rd_sel(rd_sel), .rd_data(rd_data),
        .chain_din(chain_din), .ack_next(ack_next), .chain_ack_in(chain_ack_in),
        .loc_ack(loc_ack), .chain_dout(chain_dout), .chain_ack_out(chain_ack_out)
    );

    AST_HIT_NOT_FORWARDED: assert property (@(posedge clk) disable iff (rst)
        in_window(req_addr, BASE_ADDR, NUM_REGS) |-> (!fwd_rd && !fwd_wr)); // R9

    AST_BAD_OP_NO_ACK: assert property (@(posedge clk) disable iff (rst)
        (req_rd && req_wr) |=> !loc_ack); // R10

    AST_ACK_HAS_CAUSE: assert property (@(posedge clk) disable iff (rst)
        $rose(loc_ack) |-> $past(in_window(req_addr, BASE_ADDR, NUM_REGS) && (req_rd ^ req_wr))); // R6

    generate
        if (!ACK_CHAINED) begin : g_chk_or
            AST_MISS_PASSES: assert property (@(posedge clk) disable iff (rst)
                !in_window(req_addr, BASE_ADDR, NUM_REGS) |-> chain_dout == chain_din); // R4
        end else begin : g_chk_ch
            AST_CHAIN_DATA_LAG: assert property (@(posedge clk) disable iff (rst)
                !in_window(req_addr, BASE_ADDR, NUM_REGS) |=> chain_dout == $past(chain_din)); // R8
        end
    endgenerate

endmodule

// File: tb/sim_chain_reg_node.sv
module sim_chain_reg_node;
    localparam int CLK_PERIOD = 10;
    localparam logic [9:0] BASE = 10'h1A0;
    localparam int NREG = 4;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic [9:0]  addr = '0;
    logic        rd = 1'b0, wr = 1'b0, ack_in = 1'b0;
    logic [31:0] din = '0;
    logic [31:0] dout0, dout1;
    logic        ack0, ack1, frd0, fwr0, frd1, fwr1;

    int n_chk = 0, n_fail = 0;
    bit done = 0;
    logic [31:0] model [NREG];

    typedef struct {
        logic        ack;
        logic [31:0] dout;
        string       tag;
    } exp_t;
    exp_t sb [$];

    always #(CLK_PERIOD/2) clk = ~clk;

    chain_reg_node #(.BASE_ADDR(BASE), .NUM_REGS(NREG), .ACK_CHAINED(1'b0)) u0 (
        .clk(clk), .rst(rst), .req_addr(addr), .req_rd(rd), .req_wr(wr),
        .chain_din(din), .chain_ack_in(ack_in), .chain_dout(dout0),
        .chain_ack_out(ack0), .fwd_rd(frd0), .fwd_wr(fwr0)
    );

    chain_reg_node #(.BASE_ADDR(BASE), .NUM_REGS(NREG), .ACK_CHAINED(1'b1)) u1 (
        .clk(clk), .rst(rst), .req_addr(addr), .req_rd(rd), .req_wr(wr),
        .chain_din(din), .chain_ack_in(ack_in), .chain_dout(dout1),
        .chain_ack_out(ack1), .fwd_rd(frd1), .fwd_wr(fwr1)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    function automatic logic win(input logic [9:0] a);
        return (a >= BASE) && (int'(a) < int'(BASE) + NREG);
    endfunction

    task automatic op(input logic [9:0] a, input logic r, input logic w,
                      input logic [31:0] d, input logic ai, input string tag);
        logic        hit, legal;
        logic [31:0] exp_d;
        exp_t        it;
        @(negedge clk);
        addr = a; rd = r; wr = w; din = d; ack_in = ai;
        #1;
        hit   = win(a);
        legal = r ^ w;
        exp_d = (hit && r && !w) ? model[a - BASE] : d;
        chk({tag, " OR-mode data"}, dout0, exp_d);
        chk({tag, " R9 fwd_rd"}, {31'd0, frd0}, {31'd0, r && !hit});
        chk({tag, " R9 fwd_wr"}, {31'd0, fwr0}, {31'd0, w && !hit});
        it.ack  = (hit && legal) || ai;
        it.dout = exp_d;
        it.tag  = tag;
        sb.push_back(it);
        if (hit && w && !r) model[a - BASE] = d;
    endtask

    initial begin : monitor
        exp_t it;
        forever begin
            @(posedge clk);
            #2;
            if (sb.size() > 0) begin
                it = sb.pop_front();
                chk({it.tag, " R6/R7 OR-mode ack"}, {31'd0, ack0}, {31'd0, it.ack});
                chk({it.tag, " R8 chained ack"}, {31'd0, ack1}, {31'd0, it.ack});
                chk({it.tag, " R8 chained data"}, dout1, it.dout);
            end
        end
    end

    initial begin : watchdog
        #(CLK_PERIOD * 20000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin : driver
        for (int i = 0; i < NREG; i++) model[i] = '0;
        din = 32'h1234_5678;
        repeat (3) @(negedge clk);
        // R11 reset state
        chk("R11 OR ack", {31'd0, ack0}, 32'd0);
        chk("R11 chained ack", {31'd0, ack1}, 32'd0);
        chk("R11 chained data", dout1, 32'd0);
        rst = 1'b0;

        // R11 registers read as zero after reset
        for (int i = 0; i < NREG; i++) op(BASE + 10'(i), 1, 0, 32'hCAFE_0000, 0, "R11 read");

        // R2 writes to every register, R1 index mapping
        for (int i = 0; i < NREG; i++) op(BASE + 10'(i), 0, 1, 32'hA500_0000 + i, 0, "R2 write");
        op(BASE, 0, 0, 32'h0, 0, "R6 idle");

        // R5 read back replaces upstream
        for (int i = 0; i < NREG; i++) op(BASE + 10'(i), 1, 0, 32'hFFFF_FFFF, 0, "R5 read");

        // R1 window edges, R3 writes outside the window
        op(BASE - 10'd1, 0, 1, 32'hBAD0_0001, 0, "R3 write below");
        op(BASE + 10'(NREG), 0, 1, 32'hBAD0_0002, 0, "R3 write above");
        op(BASE - 10'd1, 1, 0, 32'h0F0F_0F0F, 0, "R1 read below");
        op(BASE + 10'(NREG), 1, 0, 32'hF0F0_F0F0, 0, "R1 read above");
        op(BASE, 1, 0, 32'h0, 0, "R3 check first");
        op(BASE + 10'(NREG - 1), 1, 0, 32'h0, 0, "R3 check last");

        // R4 miss passes data, R7 upstream ack
        op(10'h005, 1, 0, 32'hDEAD_BEEF, 1, "R4 miss ack_in");
        op(10'h3FF, 0, 0, 32'h7777_0000, 1, "R7 idle ack_in");
        op(10'h3FF, 0, 0, 32'h7777_0001, 0, "R4 idle");

        // R6 held request then drop
        for (int k = 0; k < 4; k++) op(BASE + 10'd2, 1, 0, 32'h5555_0000, 0, "R6 held read");
        op(BASE + 10'd2, 0, 0, 32'h5555_0001, 0, "R6 dropped");
        op(BASE + 10'd2, 0, 0, 32'h5555_0002, 0, "R6 still low");

        // R10 illegal both strobes
        op(BASE + 10'd1, 1, 1, 32'h1111_2222, 0, "R10 both strobes");
        op(BASE + 10'd1, 1, 1, 32'h1111_3333, 0, "R10 both held");
        op(BASE + 10'd1, 1, 0, 32'h0, 0, "R10 reg intact");
        op(BASE + 10'd1, 0, 0, 32'h0, 0, "R10 idle");

        @(negedge clk);
        @(negedge clk);
        finish_run();
    end
endmodule